// File: doc/BRIEF.md
# Raster Timing Generator with Live Sync Status

This block produces the horizontal and vertical timing of a video raster. A dot-clock enable advances a dot counter across each line and a line counter down each frame. From those two counters it derives horizontal sync, vertical sync, a display-active window, an odd/even field flag and a one-cycle retrace pulse at every frame wrap.

Software programs the block over a 32-bit register bus with word addresses. One register holds the frame size, one selects interlaced scanning, one holds the sync widths, and one sets where the visible part of each line begins. A read-only status word reports the current line, the field and the sync and display flags. It is built combinationally from the running counters, so it can be polled mid-line. Written timing values are held back and take effect together at the next frame wrap.

Top module: `raster_crtc`

## Requirements
- R1: After reset the frame register (word 0x36) reads lines-minus-one in bits 25:16 and dots-minus-one in bits 9:0, taken from the default parameters. The sync register (word 0x38) reads the default vertical sync line count in bits 11:8 and the horizontal width minus one in bits 6:0. The configuration register (word 0x34) reads 0. The display start register (word 0x3B) reads the default start value.
- R2: Writes are masked as they are stored: the frame register with 0x03FF03FF, the configuration register with 0x000003FF, the sync register with 0xFFFFFF7F and the display start register with 0x000003FF. A read returns the masked value immediately.
- R3: The dot counter advances only on cycles with `dotEn` high and wraps after dots-minus-one. Each wrap advances the line counter by one.
- R4: The line counter returns to 0 after lines-minus-one. In the cycle where it first reads 0, `retrace` is high, and only in that cycle.
- R5: When interlace (configuration bit 4) is active, `field` toggles at each frame wrap. When it is not active, the wrap clears `field` to 0. Reset clears `field`.
- R6: `hsync` is high while the dot count is at or below the horizontal width minus one.
- R7: `vsync` is high on lines below the vertical sync line count, and `dispActive` is never high on those lines.
- R8: `dispActive` is high when the dot count is greater than the display start value, the dot count plus BACK_PORCH is below the dots per line, and the line is not a vertical sync line.
- R9: The status word (word 0x43) reads the line in bits 9:0, `field` in bit 10, display active in bit 11, horizontal sync inactive in bit 12 and vertical sync inactive in bit 13. Bits 31:14 read 0.
- R10: New frame, sync, interlace and display start values take effect only at the frame wrap that follows the write. Until then the running frame keeps its old timing.
- R11: A write to the status word has no effect, and a read of an unmapped word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dotEn | input | 1 | Dot-clock enable, one dot per high cycle |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| hsync | output | 1 | Horizontal sync, high while asserted |
| vsync | output | 1 | Vertical sync, high while asserted |
| dispActive | output | 1 | Visible display window |
| field | output | 1 | Field flag, 1 = odd |
| retrace | output | 1 | One-cycle frame wrap pulse |

## Verification
The bench builds the block with reset defaults of a 16-dot, 10-line frame, 2 vertical sync lines, a 3-dot horizontal sync, a display start of 3 and a back porch of 3. With these values a full frame lasts about 160 enabled dots. Tens of thousands of random cycles therefore cover many hundreds of frame wraps, interlace toggles and deferred timing changes. Random rewrites keep frames between 9 and 25 dots and between 5 and 15 lines. This brings edge cases within reach: a zero vertical sync count, a display window that closes before it opens, and writes landing in the same cycle as a wrap.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int REG_W  = 32;
  localparam int CNT_W  = 10;
  localparam int VS_W   = 4;
  localparam int HS_W   = 7;

  // word offsets of the register bus
  localparam int OFS_CFG    = 'h34;
  localparam int OFS_FRAME  = 'h36;
  localparam int OFS_SYNC   = 'h38;
  localparam int OFS_START  = 'h3B;
  localparam int OFS_STATUS = 'h43;

  localparam logic [REG_W-1:0] SYNC_KEEP = 32'hFFFF_FF7F;

  typedef struct packed {
    logic [CNT_W-1:0] linesM1;
    logic [CNT_W-1:0] dotsM1;
    logic             interlace;
    logic [VS_W-1:0]  vsyncLines;
    logic [HS_W-1:0]  hsyncM1;
    logic [CNT_W-1:0] startDot;
  } timing_t;

  typedef struct packed {
    logic dotAdv;
    logic lineAdv;
    logic frameWrap;
  } strobe_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DEF_LINES_M1 = 624,
  parameter int DEF_DOTS_M1  = 863,
  parameter int DEF_VSYNC    = 5,
  parameter int DEF_HSYNC_M1 = 107,
  parameter int DEF_START    = 324
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dotEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              atDotEnd,
  input  logic              atLineEnd,
  input  logic [REG_W-1:0]  statusWord,
  output logic [REG_W-1:0]  rdData,
  output timing_t           progCfg,
  output strobe_t           strb
);
  localparam logic [REG_W-1:0] DEF_SYNC =
    (REG_W'(DEF_VSYNC) << 8) | REG_W'(DEF_HSYNC_M1);

  logic [CNT_W-1:0] cfgReg;
  logic [CNT_W-1:0] linesReg;
  logic [CNT_W-1:0] dotsReg;
  logic [REG_W-1:0] syncReg;
  logic [CNT_W-1:0] startReg;

  logic selCfg, selFrame, selSync, selStart, selStatus;
  assign selCfg    = (addr == ADDR_W'(OFS_CFG));
  assign selFrame  = (addr == ADDR_W'(OFS_FRAME));
  assign selSync   = (addr == ADDR_W'(OFS_SYNC));
  assign selStart  = (addr == ADDR_W'(OFS_START));
  assign selStatus = (addr == ADDR_W'(OFS_STATUS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      linesReg <= CNT_W'(DEF_LINES_M1);
      dotsReg  <= CNT_W'(DEF_DOTS_M1);
      syncReg  <= DEF_SYNC;
      startReg <= CNT_W'(DEF_START);
    end else if (wrEn) begin
      if (selCfg)   cfgReg <= wrData[CNT_W-1:0];
      if (selFrame) begin
        linesReg <= wrData[16 +: CNT_W];
        dotsReg  <= wrData[CNT_W-1:0];
      end
      if (selSync)  syncReg  <= wrData & SYNC_KEEP;
      if (selStart) startReg <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    if (selCfg)    rdData = REG_W'(cfgReg);
    if (selFrame)  rdData = (REG_W'(linesReg) << 16) | REG_W'(dotsReg);
    if (selSync)   rdData = syncReg;
    if (selStart)  rdData = REG_W'(startReg);
    if (selStatus) rdData = statusWord;
  end

  always_comb begin
    progCfg.linesM1    = linesReg;
    progCfg.dotsM1     = dotsReg;
    progCfg.interlace  = cfgReg[4];
    progCfg.vsyncLines = syncReg[8 +: VS_W];
    progCfg.hsyncM1    = syncReg[HS_W-1:0];
    progCfg.startDot   = startReg;
  end

  assign strb.dotAdv    = dotEn;
  assign strb.lineAdv   = dotEn & atDotEnd;
  assign strb.frameWrap = dotEn & atDotEnd & atLineEnd;

  // R2: the stored sync register never keeps bit 7
  p_sync_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && selSync |=> syncReg[7] == 1'b0);
endmodule

// File: rtl/raster_dpath.sv
module raster_dpath
  import raster_pkg::*;
#(
  parameter int DEF_LINES_M1 = 624,
  parameter int DEF_DOTS_M1  = 863,
  parameter int DEF_VSYNC    = 5,
  parameter int DEF_HSYNC_M1 = 107,
  parameter int DEF_START    = 324,
  parameter int BACK_PORCH   = 108
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  timing_t          progCfg,
  output logic             atDotEnd,
  output logic             atLineEnd,
  output logic             hsync,
  output logic             vsync,
  output logic             dispActive,
  output logic             field,
  output logic             retrace,
  output logic [REG_W-1:0] statusWord
);
  localparam int SUM_W = CNT_W + 2;

  timing_t          actCfg;
  logic [CNT_W-1:0] dotCnt;
  logic [CNT_W-1:0] lineCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCfg.linesM1    <= CNT_W'(DEF_LINES_M1);
      actCfg.dotsM1     <= CNT_W'(DEF_DOTS_M1);
      actCfg.interlace  <= 1'b0;
      actCfg.vsyncLines <= VS_W'(DEF_VSYNC);
      actCfg.hsyncM1    <= HS_W'(DEF_HSYNC_M1);
      actCfg.startDot   <= CNT_W'(DEF_START);
      dotCnt  <= '0;
      lineCnt <= '0;
      field   <= 1'b0;
      retrace <= 1'b0;
    end else begin
      retrace <= strb.frameWrap;
      if (strb.dotAdv)  dotCnt  <= atDotEnd ? '0 : dotCnt + 1'b1;
      if (strb.lineAdv) lineCnt <= atLineEnd ? '0 : lineCnt + 1'b1;
      if (strb.frameWrap) begin
        field  <= actCfg.interlace ? ~field : 1'b0;
        actCfg <= progCfg;
      end
    end
  end

  assign atDotEnd  = (dotCnt >= actCfg.dotsM1);
  assign atLineEnd = (lineCnt >= actCfg.linesM1);

  logic [SUM_W-1:0] dotPlusPorch;
  assign dotPlusPorch = SUM_W'(dotCnt) + SUM_W'(BACK_PORCH);

  assign hsync      = (dotCnt <= CNT_W'(actCfg.hsyncM1));
  assign vsync      = (lineCnt < CNT_W'(actCfg.vsyncLines));
  assign dispActive = !vsync && (dotCnt > actCfg.startDot) &&
                      (dotPlusPorch <= SUM_W'(actCfg.dotsM1));

  assign statusWord = {18'b0, ~vsync, ~hsync, dispActive, field, lineCnt};

  // R4: retrace only with line zero, and never two cycles running
  p_retrace_line0_r4: assert property (@(posedge clk) disable iff (!rstN)
    retrace |-> lineCnt == '0);
  p_retrace_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    retrace |=> !retrace);
  // R7: no display during vertical sync
  p_no_disp_in_vsync_r7: assert property (@(posedge clk) disable iff (!rstN)
    vsync |-> !dispActive);
  // R5: field changes only at a frame wrap
  p_field_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameWrap |=> $stable(field));
  // R10: active timing holds between wraps
  p_timing_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameWrap |=> $stable(actCfg));
  // R3: dots hold without the enable
  p_dot_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dotAdv |=> $stable(dotCnt));
endmodule

// File: rtl/raster_crtc.sv
module raster_crtc
  import raster_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DEF_LINES_M1 = 624,
  parameter int DEF_DOTS_M1  = 863,
  parameter int DEF_VSYNC    = 5,
  parameter int DEF_HSYNC_M1 = 107,
  parameter int DEF_START    = 324,
  parameter int BACK_PORCH   = 108
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dotEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              hsync,
  output logic              vsync,
  output logic              dispActive,
  output logic              field,
  output logic              retrace
);
  timing_t          progCfg;
  strobe_t          strb;
  logic             atDotEnd, atLineEnd;
  logic [REG_W-1:0] statusWord;

  raster_ctrl #(
    .ADDR_W(ADDR_W), .DEF_LINES_M1(DEF_LINES_M1), .DEF_DOTS_M1(DEF_DOTS_M1),
    .DEF_VSYNC(DEF_VSYNC), .DEF_HSYNC_M1(DEF_HSYNC_M1), .DEF_START(DEF_START)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .dotEn(dotEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .atDotEnd(atDotEnd), .atLineEnd(atLineEnd),
    .statusWord(statusWord), .rdData(rdData), .progCfg(progCfg), .strb(strb)
  );

  raster_dpath #(
    .DEF_LINES_M1(DEF_LINES_M1), .DEF_DOTS_M1(DEF_DOTS_M1),
    .DEF_VSYNC(DEF_VSYNC), .DEF_HSYNC_M1(DEF_HSYNC_M1),
    .DEF_START(DEF_START), .BACK_PORCH(BACK_PORCH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .progCfg(progCfg),
    .atDotEnd(atDotEnd), .atLineEnd(atLineEnd), .hsync(hsync),
    .vsync(vsync), .dispActive(dispActive), .field(field),
    .retrace(retrace), .statusWord(statusWord)
  );
endmodule

// File: tb/raster_crtc_test.sv
module raster_crtc_test;
  localparam int LM1 = 9, DM1 = 15, VS = 2, HM1 = 2, ST = 3, BP = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dotEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        hsync, vsync, dispActive, field, retrace;

  raster_crtc #(.ADDR_W(8), .DEF_LINES_M1(LM1), .DEF_DOTS_M1(DM1),
    .DEF_VSYNC(VS), .DEF_HSYNC_M1(HM1), .DEF_START(ST), .BACK_PORCH(BP)
  ) uut (
    .clk(clk), .rstN(rstN), .dotEn(dotEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .hsync(hsync), .vsync(vsync),
    .dispActive(dispActive), .field(field), .retrace(retrace)
  );

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  int mCfg, mLines, mDots, mStart, mDot, mLine;
  logic [31:0] mSync;
  int aLines, aDots, aVs, aHs, aStart;
  bit aInt, mField, mRetrace;

  always @(posedge clk) begin
    if (!rstN) begin
      mCfg <= 0; mLines <= LM1; mDots <= DM1; mStart <= ST;
      mSync <= (VS << 8) | HM1;
      aLines <= LM1; aDots <= DM1; aVs <= VS; aHs <= HM1; aStart <= ST;
      aInt <= 1'b0; mDot <= 0; mLine <= 0; mField <= 1'b0; mRetrace <= 1'b0;
    end else begin
      mRetrace <= 1'b0;
      if (wrEn) begin
        case (addr)
          8'h34: mCfg <= wrData & 32'h3FF;
          8'h36: begin mLines <= (wrData >> 16) & 32'h3FF; mDots <= wrData & 32'h3FF; end
          8'h38: mSync <= wrData & 32'hFFFFFF7F;
          8'h3B: mStart <= wrData & 32'h3FF;
          default: ;
        endcase
      end
      if (dotEn) begin
        if (mDot >= aDots) begin
          mDot <= 0;
          if (mLine >= aLines) begin
            mLine <= 0; mRetrace <= 1'b1;
            mField <= aInt ? ~mField : 1'b0;
            aLines <= mLines; aDots <= mDots; aInt <= mCfg[4];
            aVs <= (mSync >> 8) & 32'hF; aHs <= mSync & 32'h7F; aStart <= mStart;
          end else mLine <= mLine + 1;
        end else mDot <= mDot + 1;
      end
    end
  end

  function automatic bit expH(); return mDot <= aHs; endfunction
  function automatic bit expV(); return mLine < aVs; endfunction
  function automatic bit expD();
    return !expV() && (mDot > aStart) && (mDot + BP <= aDots);
  endfunction
  function automatic logic [31:0] expStatus();
    return {18'b0, ~expV(), ~expH(), expD(), mField, 10'(mLine)};
  endfunction
  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h34: return 32'(mCfg);
      8'h36: return 32'((mLines << 16) | mDots);
      8'h38: return mSync;
      8'h3B: return 32'(mStart);
      8'h43: return expStatus();
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (line %0d dot %0d)", tag, act, exp, mLine, mDot);
    end
  endtask

  task automatic checkAll();
    chk("R6 hsync", 32'(hsync), 32'(expH()));
    chk("R7 vsync", 32'(vsync), 32'(expV()));
    chk("R8 dispActive", 32'(dispActive), 32'(expD()));
    chk("R5 field", 32'(field), 32'(mField));
    chk("R4 retrace", 32'(retrace), 32'(mRetrace));
    if (addr == 8'h43) chk("R9 status", rdData, expRead(addr));
    else if (addr == 8'h36 || addr == 8'h38 || addr == 8'h34 || addr == 8'h3B)
      chk("R2 readback", rdData, expRead(addr));
    else chk("R11 unmapped", rdData, 32'h0);
  endtask

  // one cycle: check at the falling edge, then drive new inputs
  task automatic cyc(bit en, bit we, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    checkAll();
    dotEn = en; wrEn = we; addr = a; wrData = d;
  endtask

  function automatic logic [7:0] pickAddr(int k);
    case (k)
      0: return 8'h34; 1: return 8'h36; 2: return 8'h38;
      3: return 8'h3B; 4: return 8'h43; default: return 8'h21;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values read through the bus
    @(negedge clk); addr = 8'h36;
    @(negedge clk); chk("R1 frame default", rdData, 32'((LM1 << 16) | DM1));
    addr = 8'h38;
    @(negedge clk); chk("R1 sync default", rdData, 32'((VS << 8) | HM1));
    addr = 8'h34;
    @(negedge clk); chk("R1 cfg default", rdData, 32'h0);
    addr = 8'h3B;
    @(negedge clk); chk("R1 start default", rdData, 32'(ST));
    addr = 8'h43;
    @(negedge clk); chk("R1 status at reset", rdData, 32'h0000_0000);
    // R11: status write ignored, unmapped read zero
    cyc(0, 1, 8'h43, 32'hFFFF_FFFF);
    cyc(0, 0, 8'h43, 0);
    cyc(0, 0, 8'h21, 0);
    // R2: masking on write
    cyc(0, 1, 8'h36, 32'hFC0A_FC0F);
    cyc(0, 1, 8'h38, 32'hABCD_0283);
    cyc(0, 1, 8'h34, 32'hFFFF_FC10);
    cyc(0, 1, 8'h3B, 32'hFFFF_0005);
    for (int k = 0; k < 6; k++) cyc(0, 0, pickAddr(k), 0);
    // R3, R10, R5: steady dots across several frames with interlace
    for (int i = 0; i < 900; i++) cyc(1, 0, pickAddr(i % 6), 0);
    // R3: gaps in the enable
    for (int i = 0; i < 300; i++) cyc(i % 3 == 0, 0, 8'h43, 0);
    // random mix
    for (int i = 0; i < 40000; i++) begin
      int k = $urandom_range(0, 5);
      bit en = ($urandom_range(0, 9) < 8);
      bit we = ($urandom_range(0, 99) < 2);
      int wk = $urandom_range(0, 4);
      logic [31:0] d = $urandom;
      logic [7:0] wa = pickAddr(wk);
      case (wk)
        0: d = d;
        1: d = (d & 32'hFC00_FC00) | (32'($urandom_range(4, 14)) << 16) | 32'($urandom_range(8, 24));
        2: d = (d & 32'hFFFF_F080) | (32'($urandom_range(0, 4)) << 8) | 32'($urandom_range(0, 6));
        3: d = (d & 32'hFFFF_FC00) | 32'($urandom_range(0, 12));
        default: d = d;
      endcase
      if (we) cyc(en, 1, wa, d);
      else cyc(en, 0, pickAddr(k), 0);
    end
    cyc(0, 0, 8'h43, 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule